// File: doc/BRIEF.md
# Linear Carry-Chained Multioperand Compressor

This block adds NOP operands of WIDTH bits in a single combinational path. A linear array of carry-save stages reduces the operands to a redundant pair, a sum word and a carry word. One two-input carry-propagate adder then turns that pair into an ordinary binary total. The array has one distinctive feature: only the carry word passes from one stage to the next, as a single unbroken chain. Each stage's sum word waits in a queue and is consumed later by the regular inputs of a subsequent stage.

The queue that feeds the regular inputs holds operands 1 to NOP-1 in index order, followed by the partial sum words in the order the stages produce them. Operand 0 enters the carry input of the first stage. Stage k takes queue entries 2k and 2k+1. As a result, an unpaired operand is matched with the oldest partial sum. The caller must supply operands already zero- or sign-extended with enough guard bits. All arithmetic wraps modulo 2^WIDTH.

Top module: `mop_linear_compressor`

## Requirements
- R1: Each stage is a bitwise full adder on inputs a, b and ci. Its sum word is a^b^ci. Its carry word is the bitwise majority of a, b and ci shifted left by one, with bit 0 equal to 0. The majority bit shifted out of the MSB is dropped.
- R2: Operand 0 (bits WIDTH-1:0 of the flat bus) drives the carry input of stage 0. Every later stage k takes its carry input from the carry word of stage k-1.
- R3: The regular inputs first consume operands 1 to NOP-1, two per stage, in ascending index order.
- R4: Once the operands run out, the regular inputs consume partial sum words, oldest first. An operand left without a partner is paired with the sum word of stage 0.
- R5: With NOP >= 3 there are NOP-2 stages. sum_word_o is the sum word of the last stage and carry_word_o is its carry word.
- R6: total_o equals (sum_word_o + carry_word_o) mod 2^WIDTH. This equals the sum of all operands mod 2^WIDTH.
- R7: With NOP = 2 there are no stages. sum_word_o is operand 0, carry_word_o is operand 1, and total_o is their sum.
- R8: Overflow wraps. With every operand all ones, total_o equals (2^WIDTH - NOP) mod 2^WIDTH.
- R9: Sign-extended two's-complement operands give the correct two's-complement total, as long as that total fits in WIDTH bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ops_i | input | NOP*WIDTH | Flat operand bus. Operand i occupies bits i*WIDTH +: WIDTH |
| sum_word_o | output | WIDTH | Redundant sum word |
| carry_word_o | output | WIDTH | Redundant carry word |
| total_o | output | WIDTH | Binary total, modulo 2^WIDTH |

## Verification
The bench builds six copies of the block, all 16 bits wide, with NOP set to 2, 3, 4, 5, 6 and 9. All six share the same operand values. The copies with 2 to 5 operands are small enough that the bench can predict their redundant words stage by stage. This exposes the bypass, the operand pairing order, the carry chain, and the pairing of a leftover operand with the oldest sum. The copies with 6 and 9 operands reach long chains where partial sums feed partial sums. All copies are checked against a plain modular sum, using random, all-ones and signed vectors.

// File: rtl/mop_pkg.sv
package mop_pkg;
  function automatic int unsigned stage_count(int unsigned nop);
    return (nop > 2) ? nop - 2 : 0;
  endfunction
endpackage

// File: rtl/mop_csa_stage.sv
module mop_csa_stage #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] ci_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] carry_o
);
  logic [WIDTH-1:0] maj;

  assign sum_o   = a_i ^ b_i ^ ci_i;
  assign maj     = (a_i & b_i) | (a_i & ci_i) | (b_i & ci_i);
  // MSB majority bit dropped: modulo 2^WIDTH
  assign carry_o = {maj[WIDTH-2:0], 1'b0};

  always_comb begin
    if (!$isunknown({a_i, b_i, ci_i})) begin
      assert_csa_conserve_R1: assert ((sum_o + carry_o) == (a_i + b_i + ci_i))
        else $error("csa stage loses value");
    end
  end
endmodule

// File: rtl/mop_cpa.sv
module mop_cpa #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o
);
  assign sum_o = a_i + b_i;

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      assert_cpa_R6: assert ((sum_o - a_i) == b_i)
        else $error("final adder mismatch");
    end
  end
endmodule

// File: rtl/mop_linear_compressor.sv
module mop_linear_compressor #(
  parameter int unsigned NOP   = 9,
  parameter int unsigned WIDTH = 16
) (
  input  logic [NOP*WIDTH-1:0] ops_i,
  output logic [WIDTH-1:0]     sum_word_o,
  output logic [WIDTH-1:0]     carry_word_o,
  output logic [WIDTH-1:0]     total_o
);
  import mop_pkg::*;
  localparam int unsigned NSTG = stage_count(NOP);
  localparam int unsigned NQOP = NOP - 1; // operands feeding regular inputs

  logic [WIDTH-1:0] op_w [NOP];
  logic [WIDTH-1:0] red_s, red_c;
  logic [WIDTH-1:0] sum_ref;

  for (genvar i = 0; i < NOP; i++) begin : g_unpack
    assign op_w[i] = ops_i[i*WIDTH +: WIDTH];
  end

  if (NOP == 2) begin : g_bypass
    assign red_s = op_w[0];
    assign red_c = op_w[1];
  end else begin : g_array
    logic [WIDTH-1:0] s_w [NSTG];
    logic [WIDTH-1:0] c_w [NSTG];

    for (genvar k = 0; k < NSTG; k++) begin : g_stage
      localparam int unsigned IA = 2 * k;
      localparam int unsigned IB = 2 * k + 1;
      logic [WIDTH-1:0] a, b, ci;

      // queue: operands 1..NOP-1, then partial sums oldest first
      if (IA < NQOP) begin : g_a_op
        assign a = op_w[IA+1];
      end else begin : g_a_sum
        assign a = s_w[IA-NQOP];
      end
      if (IB < NQOP) begin : g_b_op
        assign b = op_w[IB+1];
      end else begin : g_b_sum
        assign b = s_w[IB-NQOP];
      end
      if (k == 0) begin : g_ci_op
        assign ci = op_w[0];
      end else begin : g_ci_chain
        assign ci = c_w[k-1];
      end

      mop_csa_stage #(.WIDTH(WIDTH)) u_stage (
        .a_i(a), .b_i(b), .ci_i(ci), .sum_o(s_w[k]), .carry_o(c_w[k])
      );
    end

    assign red_s = s_w[NSTG-1];
    assign red_c = c_w[NSTG-1];
  end

  mop_cpa #(.WIDTH(WIDTH)) u_cpa (.a_i(red_s), .b_i(red_c), .sum_o(total_o));

  assign sum_word_o   = red_s;
  assign carry_word_o = red_c;

  always_comb begin
    sum_ref = '0;
    for (int i = 0; i < NOP; i++) sum_ref = sum_ref + op_w[i];
    if (!$isunknown(ops_i)) begin
      assert_total_R6: assert (total_o == sum_ref)
        else $error("total differs from operand sum");
      if (NOP > 2) begin
        assert_carry_lsb_R5: assert (carry_word_o[0] == 1'b0)
          else $error("carry word lsb set");
      end
    end
  end
endmodule

// File: tb/mop_linear_compressor_tb_top.sv
module mop_linear_compressor_tb_top;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;
  typedef logic [W-1:0] word_t;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  word_t op [9];
  int checks = 0, errors = 0;

  logic [2*W-1:0] ops2; logic [3*W-1:0] ops3; logic [4*W-1:0] ops4;
  logic [5*W-1:0] ops5; logic [6*W-1:0] ops6; logic [9*W-1:0] ops9;
  word_t s2, c2, t2, s3, c3, t3, s4, c4, t4, s5, c5, t5, s6, c6, t6, s9, c9, t9;

  always_comb begin
    for (int i = 0; i < 2; i++) ops2[i*W +: W] = op[i];
    for (int i = 0; i < 3; i++) ops3[i*W +: W] = op[i];
    for (int i = 0; i < 4; i++) ops4[i*W +: W] = op[i];
    for (int i = 0; i < 5; i++) ops5[i*W +: W] = op[i];
    for (int i = 0; i < 6; i++) ops6[i*W +: W] = op[i];
    for (int i = 0; i < 9; i++) ops9[i*W +: W] = op[i];
  end

  mop_linear_compressor #(.NOP(2), .WIDTH(W)) dut_i (.ops_i(ops2), .sum_word_o(s2), .carry_word_o(c2), .total_o(t2));
  mop_linear_compressor #(.NOP(3), .WIDTH(W)) dut3_i (.ops_i(ops3), .sum_word_o(s3), .carry_word_o(c3), .total_o(t3));
  mop_linear_compressor #(.NOP(4), .WIDTH(W)) dut4_i (.ops_i(ops4), .sum_word_o(s4), .carry_word_o(c4), .total_o(t4));
  mop_linear_compressor #(.NOP(5), .WIDTH(W)) dut5_i (.ops_i(ops5), .sum_word_o(s5), .carry_word_o(c5), .total_o(t5));
  mop_linear_compressor #(.NOP(6), .WIDTH(W)) dut6_i (.ops_i(ops6), .sum_word_o(s6), .carry_word_o(c6), .total_o(t6));
  mop_linear_compressor #(.NOP(9), .WIDTH(W)) dut9_i (.ops_i(ops9), .sum_word_o(s9), .carry_word_o(c9), .total_o(t9));

  function automatic word_t f_sum(int n);
    word_t acc = '0;
    for (int i = 0; i < n; i++) acc = acc + op[i];
    return acc;
  endfunction

  function automatic word_t f_xor(word_t a, word_t b, word_t c);
    return a ^ b ^ c;
  endfunction

  function automatic word_t f_cy(word_t a, word_t b, word_t c);
    word_t m = (a & b) | (a & c) | (b & c);
    return {m[W-2:0], 1'b0};
  endfunction

  task automatic chk(string req, word_t act, word_t exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(bit full);
    word_t es0, ec0, es1, ec1, es2, ec2;
    @(negedge clk);
    if (full) begin
      // R7: bypass
      chk("R7 sum", s2, op[0]);
      chk("R7 carry", c2, op[1]);
      // R1: single stage
      chk("R1 sum", s3, f_xor(op[1], op[2], op[0]));
      chk("R1 carry", c3, f_cy(op[1], op[2], op[0]));
      // R2/R3: NOP=4 -> (I0;I1,I2) then (c0;I3,s0)
      es0 = f_xor(op[1], op[2], op[0]); ec0 = f_cy(op[1], op[2], op[0]);
      chk("R2 sum", s4, f_xor(op[3], es0, ec0));
      chk("R3 carry", c4, f_cy(op[3], es0, ec0));
      // R4/R5: NOP=5 -> (I0;I1,I2) (c0;I3,I4) (c1;s0,s1)
      es1 = f_xor(op[3], op[4], ec0); ec1 = f_cy(op[3], op[4], ec0);
      es2 = f_xor(es0, es1, ec1);     ec2 = f_cy(es0, es1, ec1);
      chk("R4 sum", s5, es2);
      chk("R5 carry", c5, ec2);
    end
    chk("R7 total", t2, f_sum(2));
    chk("R6 total3", t3, f_sum(3));
    chk("R6 total4", t4, f_sum(4));
    chk("R6 total5", t5, f_sum(5));
    chk("R6 total6", t6, f_sum(6));
    chk("R6 total9", t9, f_sum(9));
    chk("R6 pair9", word_t'(s9 + c9), t9);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // zero operands
    for (int i = 0; i < 9; i++) op[i] = '0;
    check_all(1);
    chk("R6 zero", t9, '0);
    // R8: all ones wraps to 2^W - NOP
    for (int i = 0; i < 9; i++) op[i] = '1;
    check_all(1);
    chk("R8 wrap9", t9, word_t'(17'h10000 - 9));
    chk("R8 wrap4", t4, word_t'(17'h10000 - 4));
    // single hot operand per position exposes pairing
    for (int p = 0; p < 9; p++) begin
      for (int i = 0; i < 9; i++) op[i] = '0;
      op[p] = 16'h8421;
      check_all(1);
    end
    // R9: signed operands
    for (int i = 0; i < 9; i++) op[i] = (i % 2) ? word_t'(-(i * 300)) : word_t'(i * 17);
    check_all(1);
    chk("R9 signed", t9, word_t'(-(1*300 + 3*300 + 5*300 + 7*300) + (2*17 + 4*17 + 6*17 + 8*17)));
    // random
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < 9; i++) op[i] = word_t'($urandom);
      check_all(1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule